// File: doc/BRIEF.md
# DRAM Periodic Refresh Scheduler

This block sits inside a DRAM memory controller and decides when a REFRESH command is due. A timebase tick advances an interval timer. Each time the timer completes one average refresh interval, the block adds a credit to a count of pending refreshes. The interval is normally 7.8125 µs. It is cut in half while the high-temperature input is set, because a hot device must be refreshed twice as often. This keeps the required 8192 refreshes within every 64 ms window at normal temperature.

While refreshes are owed and no refresh cycle is running, the block raises a request. The controller's command arbiter answers with a grant. A grant is accepted only if every bank is idle. An accepted grant removes one credit and starts a busy window of tRFC controller cycles. During that window the arbiter must issue nothing but NOP or DESELECT. A grant that arrives while a bank is still open is refused and flagged. Up to eight refreshes may be postponed, and the request is marked urgent once the count is full. The interval is given in ticks and tRFC in controller clock cycles, both as parameters.

Top module: `ref_sched`

## Requirements
- R1: After reset, ref_req, ref_urgent, ref_busy and grant_err are 0 and pend_cnt is 0.
- R2: With hot low, pend_cnt rises by one on the NORM_TICKS-th cycle with tick high since the previous credit. Cycles with tick low do not advance the interval.
- R3: With hot high, a credit is added after NORM_TICKS/2 tick cycles instead.
- R4: ref_req is high exactly when pend_cnt is nonzero and ref_busy is low. It stays high until a grant is accepted.
- R5: A grant while ref_req and all_idle are both high is accepted. pend_cnt drops by one (net of any credit added in the same cycle), and ref_busy rises in the next cycle.
- R6: After an accepted grant, ref_busy stays high for exactly TRFC_CYC cycles, and ref_req is low for that whole time.
- R7: A grant while ref_req is high and all_idle is low raises grant_err for exactly the next cycle. It leaves pend_cnt unchanged and does not start a busy window.
- R8: pend_cnt saturates at MAX_PEND (default 8). ref_urgent is high exactly when pend_cnt equals MAX_PEND.
- R9: A grant while ref_req is low has no effect: pend_cnt, ref_busy and grant_err stay unchanged.
- R10: If hot rises while the interval count has already passed the hot limit, the next tick completes the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase pulse that advances the interval timer |
| hot | input | 1 | Case temperature above 85 °C; halves the interval |
| grant | input | 1 | Arbiter grants the refresh request this cycle |
| all_idle | input | 1 | Every bank is precharged |
| ref_req | output | 1 | A refresh is owed and may be issued |
| ref_urgent | output | 1 | The postponement budget is used up |
| ref_busy | output | 1 | Refresh cycle in progress; only NOP/DESELECT allowed |
| pend_cnt | output | $clog2(MAX_PEND+1) | Number of refreshes owed |
| grant_err | output | 1 | Previous cycle's grant arrived with a bank open |

## Verification
The bench drives the interval exactly to its last tick and one tick further. A timer that is off by one would credit a cycle early or late. It flips hot in the middle of an interval after the count has passed the hot limit; a timer that compares for equality would then run through a whole counter wrap before crediting. It fills the credit counter to eight and keeps ticking, which exposes counters that wrap to zero or drop urgent. It also grants with a bank open and grants with nothing pending, which shows a design that consumes credits or starts tRFC on a refused or spurious grant.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;

   // events that move the credit count in one cycle
   typedef struct packed {
      logic elapse;   // an interval completed
      logic accept;   // a refresh was granted with every bank idle
   } credit_evt_t;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
   parameter int unsigned NORM_TICKS = 780,
   parameter bit          USE_TICK   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic hot,
   output logic elapse
);
   localparam int unsigned HOT_TICKS = NORM_TICKS / 2;
   localparam int unsigned TW        = ref_sched_pkg::cnt_width(NORM_TICKS);

   logic [TW-1:0] cnt_q;
   logic [TW-1:0] lim_m1;
   logic          step;

   generate
      if (USE_TICK) begin : g_tick_step
         assign step = tick;
      end else begin : g_clock_step
         assign step = tick | 1'b1;
      end
   endgenerate

   assign lim_m1 = hot ? TW'(HOT_TICKS - 1) : TW'(NORM_TICKS - 1);
   // compare with >= so a switch to the hot limit cannot overshoot
   assign elapse = step && (cnt_q >= lim_m1);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (elapse) cnt_q <= '0;
      else if (step)   cnt_q <= cnt_q + 1'b1;
   end

   // R2: the count never reaches the normal interval length
   p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < TW'(NORM_TICKS));

   // R2: without a step, the count holds
   p_hold_without_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt_q));

endmodule

// File: rtl/ref_credit_ctr.sv
module ref_credit_ctr #(
   parameter int unsigned MAX_PEND = 8,
   parameter int unsigned PW       = ref_sched_pkg::cnt_width(MAX_PEND)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  ref_sched_pkg::credit_evt_t evt,
   output logic [PW-1:0]              pend,
   output logic                       urgent
);
   logic full;
   logic inc;

   assign full   = (pend == PW'(MAX_PEND));
   assign inc    = evt.elapse && (!full || evt.accept);
   assign urgent = full;

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= pend + PW'(inc) - PW'(evt.accept);
   end

   // R8: the count is bounded by the postponement budget
   p_pend_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pend <= PW'(MAX_PEND));

   // R2: no event means no change
   p_pend_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt.elapse || evt.accept) |=> $stable(pend));

endmodule

// File: rtl/ref_busy_timer.sv
module ref_busy_timer #(
   parameter int unsigned TRFC_CYC = 28
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int unsigned BW = ref_sched_pkg::cnt_width(TRFC_CYC);

   logic [BW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n)           left_q <= '0;
      else if (start)       left_q <= BW'(TRFC_CYC);
      else if (left_q != 0) left_q <= left_q - 1'b1;
   end

   assign busy = (left_q != '0);

   // R5: an accepted refresh opens the busy window at once
   p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   // R6: the window never restarts from inside itself
   p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);

endmodule

// File: rtl/ref_sched.sv
module ref_sched #(
   parameter int unsigned NORM_TICKS = 780,
   parameter int unsigned TRFC_CYC   = 28,
   parameter int unsigned MAX_PEND   = 8,
   parameter bit          USE_TICK   = 1'b1,
   parameter int unsigned PW         = ref_sched_pkg::cnt_width(MAX_PEND)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          hot,
   input  logic          grant,
   input  logic          all_idle,
   output logic          ref_req,
   output logic          ref_urgent,
   output logic          ref_busy,
   output logic [PW-1:0] pend_cnt,
   output logic          grant_err
);
   generate
      if (NORM_TICKS < 4 || (NORM_TICKS % 2) != 0) begin : g_bad_interval
         $error("NORM_TICKS must be even and at least 4");
      end
      if (TRFC_CYC < 1) begin : g_bad_trfc
         $error("TRFC_CYC must be at least 1");
      end
      if (MAX_PEND < 1) begin : g_bad_pend
         $error("MAX_PEND must be at least 1");
      end
   endgenerate

   ref_sched_pkg::credit_evt_t evt;
   logic elapse;
   logic accept;
   logic reject;
   logic err_q;

   ref_interval_timer #(.NORM_TICKS(NORM_TICKS), .USE_TICK(USE_TICK)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hot(hot), .elapse(elapse));

   assign ref_req = (pend_cnt != '0) && !ref_busy;
   assign accept  = grant && ref_req && all_idle;
   assign reject  = grant && ref_req && !all_idle;

   assign evt.elapse = elapse;
   assign evt.accept = accept;

   ref_credit_ctr #(.MAX_PEND(MAX_PEND), .PW(PW)) u_credit (
      .clk(clk), .rst_n(rst_n), .evt(evt), .pend(pend_cnt), .urgent(ref_urgent));

   ref_busy_timer #(.TRFC_CYC(TRFC_CYC)) u_busy (
      .clk(clk), .rst_n(rst_n), .start(accept), .busy(ref_busy));

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= reject;
   end
   assign grant_err = err_q;

   // R6: no request while a refresh cycle runs
   p_busy_blocks_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ref_busy |-> !ref_req);

   // R7: a refused grant is flagged in the next cycle
   p_reject_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && ref_req && !all_idle) |=> grant_err);

   // R7: a refused grant consumes no credit and starts no window
   p_reject_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && ref_req && !all_idle && !elapse) |=> ($stable(pend_cnt) && !ref_busy));

   // R4: an ungranted request persists
   p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && !grant) |=> ref_req);

   // R9: a grant without a request leaves the busy state alone
   p_stray_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && !ref_req && !ref_busy) |=> !ref_busy);

endmodule

// File: tb/ref_sched_test.sv
module ref_sched_test;
   localparam int NORM = 24;
   localparam int HOTT = NORM / 2;
   localparam int TRFC = 5;
   localparam int MAXP = 8;
   localparam int PW   = $clog2(MAXP + 1);

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, hot = 1'b0, grant = 1'b0, all_idle = 1'b1;
   logic ref_req, ref_urgent, ref_busy, grant_err;
   logic [PW-1:0] pend_cnt;

   ref_sched #(.NORM_TICKS(NORM), .TRFC_CYC(TRFC), .MAX_PEND(MAXP)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hot(hot), .grant(grant),
      .all_idle(all_idle), .ref_req(ref_req), .ref_urgent(ref_urgent),
      .ref_busy(ref_busy), .pend_cnt(pend_cnt), .grant_err(grant_err));

   always #5 clk = ~clk;

   int n_tests = 0, n_fail = 0;
   int m_tcnt = 0, m_pend = 0, m_busy = 0;
   bit m_err = 0;
   bit done = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int exp_req();
      return (m_pend != 0 && m_busy == 0) ? 1 : 0;
   endfunction

   task automatic compare();
      chk("R4 ref_req", int'(ref_req), exp_req());
      chk("R2 pend_cnt", int'(pend_cnt), m_pend);
      chk("R6 ref_busy", int'(ref_busy), (m_busy != 0) ? 1 : 0);
      chk("R8 ref_urgent", int'(ref_urgent), (m_pend == MAXP) ? 1 : 0);
      chk("R7 grant_err", int'(grant_err), int'(m_err));
   endtask

   // drive one cycle from a negedge, advance the model, sample at the next negedge
   task automatic step(input bit tk, input bit ht, input bit gr, input bit id);
      int lim;
      bit el, rq, acc;
      tick = tk; hot = ht; grant = gr; all_idle = id;
      lim = ht ? HOTT : NORM;
      el  = tk && (m_tcnt >= lim - 1);
      m_tcnt = el ? 0 : (tk ? m_tcnt + 1 : m_tcnt);
      rq  = (exp_req() != 0);
      acc = gr && rq && id;
      m_err = gr && rq && !id;
      if (el && (m_pend != MAXP || acc)) m_pend++;
      if (acc) m_pend--;
      m_busy = acc ? TRFC : ((m_busy > 0) ? m_busy - 1 : 0);
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements): actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int cnt;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 ref_req", int'(ref_req), 0);
      chk("R1 ref_busy", int'(ref_busy), 0);
      chk("R1 pend_cnt", int'(pend_cnt), 0);
      chk("R1 grant_err", int'(grant_err), 0);
      chk("R1 ref_urgent", int'(ref_urgent), 0);
      rst_n = 1'b1;

      // R9: grant with nothing owed changes nothing
      step(0, 0, 1, 1);
      chk("R9 busy after stray grant", int'(ref_busy), 0);
      chk("R9 err after stray grant", int'(grant_err), 0);

      // R2: normal interval, idle cycles do not count
      for (int i = 0; i < NORM - 1; i++) step(1, 0, 0, 1);
      repeat (4) step(0, 0, 0, 1);
      chk("R2 no credit before last tick", int'(pend_cnt), 0);
      step(1, 0, 0, 1);
      chk("R2 credit on last tick", int'(pend_cnt), 1);
      chk("R4 request raised", int'(ref_req), 1);

      // R5, R6: accept and busy length
      step(0, 0, 1, 1);
      chk("R5 credit consumed", int'(pend_cnt), 0);
      cnt = 0;
      while (ref_busy && cnt < 50) begin
         cnt++;
         step(0, 0, 0, 1);
      end
      chk("R6 busy length", cnt, TRFC);

      // R3: hot interval is half as long
      for (int i = 0; i < HOTT - 1; i++) step(1, 1, 0, 1);
      chk("R3 no credit before hot limit", int'(pend_cnt), 0);
      step(1, 1, 0, 1);
      chk("R3 credit at hot limit", int'(pend_cnt), 1);

      // R10: hot rises after the count has passed the hot limit
      for (int i = 0; i < 20; i++) step(1, 0, 0, 1);
      chk("R10 still one credit", int'(pend_cnt), 1);
      step(1, 1, 0, 1);
      chk("R10 credit on first hot tick", int'(pend_cnt), 2);

      // R7: grant with a bank open
      step(0, 1, 1, 0);
      chk("R7 error flagged", int'(grant_err), 1);
      chk("R7 credit kept", int'(pend_cnt), 2);
      chk("R7 no busy", int'(ref_busy), 0);
      step(0, 1, 0, 1);
      chk("R7 error one cycle", int'(grant_err), 0);

      // R8: saturation and urgency
      for (int i = 0; i < HOTT * (MAXP - 2); i++) step(1, 1, 0, 1);
      chk("R8 saturated count", int'(pend_cnt), MAXP);
      chk("R8 urgent", int'(ref_urgent), 1);
      for (int i = 0; i < HOTT * 2; i++) step(1, 1, 0, 1);
      chk("R8 stays saturated", int'(pend_cnt), MAXP);

      // random traffic against the model
      for (int i = 0; i < 3000; i++) begin
         bit tk, gr, id;
         bit ht;
         tk = ($urandom % 4) != 0;
         gr = ($urandom % 3) == 0;
         id = ($urandom % 5) != 0;
         ht = (($urandom % 200) == 0) ? !hot : hot;
         step(tk, ht, gr, id);
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule